// File: doc/BRIEF.md
# Synchronous Host-Bus Target Bridge

This block sits between an 8-bit synchronous host bus and the user logic of a chip. The host drives a 5-bit address, two chip selects (one active low, one active high), a read/write line (high means read) and an active-low transfer-start strobe. The bridge answers each transfer with a one-cycle active-low acknowledge, paired with an active-low burst-inhibit, since only single transfers are handled. The host can also see a user interrupt, which is passed through to it.

The top address bit picks between two spaces of 16 locations each. When it is low, the access goes to an internal register bank outside this block through a shared location address, a write strobe and a read-data input. When it is high, the bridge gives the user logic the low address bits, a read flag with a fixed polarity, write data and a one-cycle start pulse. It then stalls the host with wait states until the user logic returns an end handshake. A watchdog ends a user access that never finishes. The pads are not part of the block: it produces a data output-enable that an outside tri-state cell can use.

Top module: `hbus_target_bridge`

## Requirements
- R1: A transfer is accepted only when, at a rising edge in the idle state, transfer-start is low, the active-low chip select is low and the active-high chip select is high. Otherwise no acknowledge and no start pulse follow.
- R2: Host write data is sampled at the rising edge one cycle after the edge that accepted the transfer. It is then held on `wdata_o` until the next transfer.
- R3: The acknowledge is low for exactly one cycle per transfer, and burst-inhibit is low in that same cycle and in no other.
- R4: Internal space (address bit 4 = 0): the acknowledge is low in the second cycle after the accepting edge. For a write, `reg_wr_o` pulses in the acknowledge cycle. For a read, `reg_rdata_i` is sampled at the end of the first cycle.
- R5: User space (address bit 4 = 1): `loc_addr_o` carries address bits 3:0. `usr_rd_o` is 1 for a host read and 0 for a host write. `usr_start_o` is high for exactly one cycle, the second cycle after the accepting edge, and it never pulses for an internal access.
- R6: The acknowledge follows in the cycle after the first rising edge at which `usr_end_i` is high while the bridge waits. An end signal held high during the start cycle gives an acknowledge in the third cycle after the accepting edge.
- R7: For a read, `rdata_o` holds the read data during the acknowledge cycle.
- R8: `data_oe_o` is high only from the cycle after the accepting edge through the acknowledge cycle of a read, and it is low in the cycle after the acknowledge.
- R9: `irq_n_o` follows `usr_irq_n_i` without a clock and independently of transfers. `irq_pend_o` shows the inverted request one edge later and stays set as long as the request is held.
- R10: If no end arrives within WDOG_CYCLES waiting cycles (default 256), the acknowledge is given in the next cycle, read data is 0xFF and `timeout_o` is set. The flag stays set until the next accepted transfer clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select |
| cs_i | input | 1 | Active-high chip select |
| rnw_i | input | 1 | Host direction, 1 = read |
| ts_n_i | input | 1 | Active-low transfer start |
| addr_i | input | 5 | Host address, bit 4 picks the space |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data towards the host |
| data_oe_o | output | 1 | Data-bus output enable for the pad cells |
| ack_n_o | output | 1 | Active-low transfer acknowledge |
| burst_inh_n_o | output | 1 | Active-low burst inhibit |
| irq_n_o | output | 1 | Active-low interrupt to the host |
| loc_addr_o | output | 4 | Location address for either space |
| wdata_o | output | 8 | Captured write data |
| reg_wr_o | output | 1 | Write strobe to the internal register bank |
| reg_rdata_i | input | 8 | Read data from the internal register bank |
| usr_rd_o | output | 1 | User-side direction, 1 = read |
| usr_start_o | output | 1 | One-cycle user transfer start |
| usr_end_i | input | 1 | User transfer end handshake |
| usr_rdata_i | input | 8 | Read data from user logic |
| usr_irq_n_i | input | 1 | Active-low user interrupt request |
| irq_pend_o | output | 1 | Registered interrupt-pending status bit |
| timeout_o | output | 1 | Set when the watchdog ended a transfer |

## Verification
The hardest case to reach from the ports is a watchdog expiry, and the one after it is a timed-out read followed by a normal transfer that has to clear the flag. The bench acts as the user logic and, for one vector, never answers the start pulse. The bridge then waits the full default window. The next vector finishes normally, so the flag is checked both when it is set and when it is cleared. Other vectors return the end signal at different delays, including at the same time as the start pulse, to cover every acknowledge latency.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_WAIT = 2'd2,
    ST_ACK  = 2'd3
  } hbb_state_e;

  // Source of the read-data register load
  typedef enum logic [1:0] {
    RSRC_NONE = 2'd0,
    RSRC_REG  = 2'd1,
    RSRC_USR  = 2'd2,
    RSRC_FILL = 2'd3
  } hbb_rsrc_e;

endpackage

// File: rtl/hbb_rst_sync.sv
module hbb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/hbb_decode.sv
module hbb_decode (
  input  logic cs_n_i,
  input  logic cs_i,
  input  logic ts_n_i,
  output logic selected_o,
  output logic begin_o
);

  always_comb begin
    selected_o = !cs_n_i && cs_i;
    begin_o    = selected_o && !ts_n_i;
  end

endmodule

// File: rtl/hbb_ctrl.sv
module hbb_ctrl
  import hbb_pkg::*;
#(
  parameter int WDOG_CYCLES = 256
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      begin_i,
  input  logic      space_i,
  input  logic      end_i,
  output hbb_state_e state_o,
  output logic      hdr_en_o,
  output logic      wd_en_o,
  output hbb_rsrc_e rsrc_o,
  output logic      start_o,
  output logic      timeout_o
);

  localparam int CW = $clog2(WDOG_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WDOG_CYCLES - 1);

  hbb_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          start_q, start_d;
  logic          to_q, to_d;
  logic          expire;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    start_d  = 1'b0;
    to_d     = to_q;
    hdr_en_o = 1'b0;
    wd_en_o  = 1'b0;
    rsrc_o   = RSRC_NONE;
    expire   = (cnt_q == LAST);
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (begin_i) begin
          hdr_en_o = 1'b1;
          to_d     = 1'b0;
          state_d  = ST_DATA;
        end
      end
      ST_DATA: begin
        wd_en_o = 1'b1;
        if (space_i) begin
          start_d = 1'b1;
          state_d = ST_WAIT;
        end else begin
          rsrc_o  = RSRC_REG;
          state_d = ST_ACK;
        end
      end
      ST_WAIT: begin
        cnt_d = cnt_q + 1'b1;
        if (end_i) begin
          rsrc_o  = RSRC_USR;
          state_d = ST_ACK;
        end else if (expire) begin
          rsrc_o  = RSRC_FILL;
          to_d    = 1'b1;
          state_d = ST_ACK;
        end
      end
      default: begin
        cnt_d   = '0;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      start_q <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
      to_q    <= to_d;
    end
  end

  assign state_o   = state_q;
  assign start_o   = start_q;
  assign timeout_o = to_q;

endmodule

// File: rtl/hbb_datapath.sv
module hbb_datapath
  import hbb_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdr_en_i,
  input  logic          wd_en_i,
  input  hbb_rsrc_e     rsrc_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rnw_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] reg_rdata_i,
  input  logic [DW-1:0] usr_rdata_i,
  input  logic          usr_irq_n_i,
  output logic          space_o,
  output logic          rd_o,
  output logic [AW-2:0] loc_addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          irq_pend_o
);

  logic [AW-1:0] addr_q;
  logic          rd_q;
  logic [DW-1:0] wd_q, rd_data_q, rd_data_d;
  logic          irq_q;

  always_comb begin
    case (rsrc_i)
      RSRC_REG:  rd_data_d = reg_rdata_i;
      RSRC_USR:  rd_data_d = usr_rdata_i;
      RSRC_FILL: rd_data_d = '1;
      default:   rd_data_d = rd_data_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      rd_q      <= 1'b0;
      wd_q      <= '0;
      rd_data_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (hdr_en_i) begin
        addr_q <= addr_i;
        rd_q   <= rnw_i;
      end
      if (wd_en_i) wd_q <= wdata_i;
      rd_data_q <= rd_data_d;
      irq_q     <= !usr_irq_n_i;
    end
  end

  assign space_o    = addr_q[AW-1];
  assign loc_addr_o = addr_q[AW-2:0];
  assign rd_o       = rd_q;
  assign wdata_o    = wd_q;
  assign rdata_o    = rd_data_q;
  assign irq_pend_o = irq_q;

endmodule

// File: rtl/hbus_target_bridge.sv
module hbus_target_bridge
  import hbb_pkg::*;
#(
  parameter int AW          = 5,
  parameter int DW          = 8,
  parameter int WDOG_CYCLES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_i,
  input  logic          cs_i,
  input  logic          rnw_i,
  input  logic          ts_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          data_oe_o,
  output logic          ack_n_o,
  output logic          burst_inh_n_o,
  output logic          irq_n_o,
  output logic [AW-2:0] loc_addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          reg_wr_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          usr_rd_o,
  output logic          usr_start_o,
  input  logic          usr_end_i,
  input  logic [DW-1:0] usr_rdata_i,
  input  logic          usr_irq_n_i,
  output logic          irq_pend_o,
  output logic          timeout_o
);

  logic       rst_n_s;
  logic       selected, begin_x;
  logic       hdr_en, wd_en, space_q, rd_q;
  hbb_rsrc_e  rsrc;
  hbb_state_e state;

  hbb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  hbb_decode u_dec (
    .cs_n_i(cs_n_i), .cs_i(cs_i), .ts_n_i(ts_n_i),
    .selected_o(selected), .begin_o(begin_x)
  );

  hbb_ctrl #(.WDOG_CYCLES(WDOG_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .begin_i(begin_x), .space_i(space_q),
    .end_i(usr_end_i), .state_o(state), .hdr_en_o(hdr_en),
    .wd_en_o(wd_en), .rsrc_o(rsrc), .start_o(usr_start_o),
    .timeout_o(timeout_o)
  );

  hbb_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n_s), .hdr_en_i(hdr_en), .wd_en_i(wd_en),
    .rsrc_i(rsrc), .addr_i(addr_i), .rnw_i(rnw_i), .wdata_i(wdata_i),
    .reg_rdata_i(reg_rdata_i), .usr_rdata_i(usr_rdata_i),
    .usr_irq_n_i(usr_irq_n_i), .space_o(space_q), .rd_o(rd_q),
    .loc_addr_o(loc_addr_o), .wdata_o(wdata_o), .rdata_o(rdata_o),
    .irq_pend_o(irq_pend_o)
  );

  // selected is consumed only through begin_x; keep it for readability
  logic unused_sel;
  assign unused_sel = selected;

  always_comb begin
    ack_n_o       = !(state == ST_ACK);
    burst_inh_n_o = !(state == ST_ACK);
    data_oe_o     = rd_q && (state != ST_IDLE);
    reg_wr_o      = (state == ST_ACK) && !rd_q && !space_q;
    usr_rd_o      = rd_q;
    irq_n_o       = usr_irq_n_i;
  end

endmodule

// File: rtl/hbb_checker.sv
module hbb_checker #(
  parameter int WDOG_CYCLES = 256
) (
  input logic clk,
  input logic rst_n,
  input logic ack_n_o,
  input logic burst_inh_n_o,
  input logic usr_start_o,
  input logic data_oe_o,
  input logic usr_irq_n_i,
  input logic irq_pend_o
);

  int unsigned since_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      since_start <= 0;
    else if (usr_start_o)            since_start <= 1;
    else if (!ack_n_o)               since_start <= 0;
    else if (since_start != 0)       since_start <= since_start + 1;
  end

  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_o |=> ack_n_o);

  p_bi_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n_o == burst_inh_n_o);

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    usr_start_o |=> !usr_start_o);

  p_start_not_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    usr_start_o |-> ack_n_o);

  p_oe_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_o |=> !data_oe_o);

  p_irq_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !usr_irq_n_i |=> irq_pend_o);

  p_wait_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    since_start <= WDOG_CYCLES + 1);

endmodule

bind hbus_target_bridge hbb_checker #(.WDOG_CYCLES(WDOG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_n_o(ack_n_o), .burst_inh_n_o(burst_inh_n_o),
  .usr_start_o(usr_start_o), .data_oe_o(data_oe_o),
  .usr_irq_n_i(usr_irq_n_i), .irq_pend_o(irq_pend_o)
);

// File: tb/hbus_target_bridge_test.sv
`timescale 1ns/1ps
module hbus_target_bridge_test;

  localparam int W = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, cs, rnw, ts_n, reg_wr, usr_rd, usr_start, usr_end;
  logic       usr_irq_n, irq_n, irq_pend, timeout, oe, ack_n, bi_n;
  logic [4:0] addr;
  logic [3:0] loc_addr;
  logic [7:0] wdata, rdata, wdata_q, reg_rdata, usr_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  hbus_target_bridge uut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .cs_i(cs), .rnw_i(rnw),
    .ts_n_i(ts_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .data_oe_o(oe), .ack_n_o(ack_n), .burst_inh_n_o(bi_n), .irq_n_o(irq_n),
    .loc_addr_o(loc_addr), .wdata_o(wdata_q), .reg_wr_o(reg_wr),
    .reg_rdata_i(reg_rdata), .usr_rd_o(usr_rd), .usr_start_o(usr_start),
    .usr_end_i(usr_end), .usr_rdata_i(usr_rdata), .usr_irq_n_i(usr_irq_n),
    .irq_pend_o(irq_pend), .timeout_o(timeout)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Vector: {rd, addr[4:0], wd[7:0], dly[7:0] (255 = never end), ud[7:0], rr[7:0]}
  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 5'h03, 8'h00, 8'd0,   8'h00, 8'h5A},
    {1'b0, 5'h07, 8'hC3, 8'd0,   8'h00, 8'h00},
    {1'b1, 5'h12, 8'h00, 8'd0,   8'hA5, 8'h11},
    {1'b0, 5'h1F, 8'h3C, 8'd4,   8'h00, 8'h00},
    {1'b1, 5'h18, 8'h00, 8'd9,   8'h81, 8'h22},
    {1'b1, 5'h10, 8'h00, 8'd255, 8'h42, 8'h00},
    {1'b0, 5'h11, 8'h99, 8'd1,   8'h00, 8'h00},
    {1'b1, 5'h0F, 8'h00, 8'd0,   8'h00, 8'h00}
  };

  task automatic xfer(input logic [37:0] v);
    logic       r    = v[37];
    logic [4:0] a    = v[36:32];
    logic [7:0] wd   = v[31:24];
    int         dly  = int'(v[23:16]);
    logic [7:0] ud   = v[15:8];
    logic [7:0] rr   = v[7:0];
    bit         usr  = a[4];
    int         k    = 0;
    int         seen = -1;
    int         exp_lat;
    logic [7:0] exp_d;
    bit         done = 0;
    if (!usr)           begin exp_lat = 2;       exp_d = rr;    end
    else if (dly > 254) begin exp_lat = 2 + W;   exp_d = 8'hFF; end
    else                begin exp_lat = 3 + dly; exp_d = ud;    end
    @(negedge clk);
    cs_n = 0; cs = 1; rnw = r; addr = a; ts_n = 0;
    reg_rdata = rr; usr_rdata = ud; wdata = 8'hEE;
    while (!done && k < 400) begin
      @(negedge clk);
      k++;
      if (k == 1) begin ts_n = 1; wdata = wd; end
      if (k == 2) wdata = 8'h00;
      if (usr_start) begin
        if (seen < 0) seen = k;
        chk("R5", "usr_start on internal access", {31'd0, usr}, 32'd1);
        chk("R5", "start cycle", k, 2);
        chk("R5", "loc_addr", {28'd0, loc_addr}, {28'd0, a[3:0]});
        chk("R5", "usr_rd polarity", {31'd0, usr_rd}, {31'd0, r});
        if (!r) chk("R2", "write data at start", {24'd0, wdata_q}, {24'd0, wd});
      end
      usr_end = (seen > 0) && (dly < 255) && (k == seen + dly);
      if (k >= 1 && ack_n)
        chk("R8", "oe during transfer", {31'd0, oe}, {31'd0, r});
      if (!ack_n) begin
        done = 1;
        chk(usr ? "R6" : "R4", "ack latency", k, exp_lat);
        chk("R3", "burst inhibit with ack", {31'd0, bi_n}, 32'd0);
        chk("R8", "oe in ack cycle", {31'd0, oe}, {31'd0, r});
        if (r) chk("R7", "read data", {24'd0, rdata}, {24'd0, exp_d});
        if (!usr) chk("R4", "reg_wr pulse", {31'd0, reg_wr}, {31'd0, !r});
        if (!usr && !r) chk("R2", "write data", {24'd0, wdata_q}, {24'd0, wd});
        if (usr && dly > 254) chk("R10", "timeout set", {31'd0, timeout}, 32'd1);
        if (usr && dly < 255) chk("R10", "timeout clear", {31'd0, timeout}, 32'd0);
      end
    end
    if (!done) chk("R6", "ack never seen", 32'd0, 32'd1);
    usr_end = 0;
    cs_n = 1; cs = 0;
    @(negedge clk);
    chk("R3", "ack released", {31'd0, ack_n}, 32'd1);
    chk("R3", "burst inhibit released", {31'd0, bi_n}, 32'd1);
    chk("R8", "oe released", {31'd0, oe}, 32'd0);
    chk("R4", "reg_wr released", {31'd0, reg_wr}, 32'd0);
  endtask

  task automatic no_accept(input logic csn, input logic csv);
    @(negedge clk);
    cs_n = csn; cs = csv; ts_n = 0; rnw = 1; addr = 5'h15;
    @(negedge clk);
    ts_n = 1;
    for (int i = 0; i < 4; i++) begin
      chk("R1", "no ack when unselected", {31'd0, ack_n}, 32'd1);
      chk("R1", "no start when unselected", {31'd0, usr_start}, 32'd0);
      @(negedge clk);
    end
    cs_n = 1; cs = 0;
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    rst_n = 0; cs_n = 1; cs = 0; rnw = 0; ts_n = 1; addr = '0; wdata = '0;
    reg_rdata = '0; usr_rdata = '0; usr_end = 0; usr_irq_n = 1;
    repeat (3) @(negedge clk);
    chk("R3", "reset ack", {31'd0, ack_n}, 32'd1);
    chk("R3", "reset burst inhibit", {31'd0, bi_n}, 32'd1);
    chk("R8", "reset oe", {31'd0, oe}, 32'd0);
    chk("R5", "reset start", {31'd0, usr_start}, 32'd0);
    chk("R10", "reset timeout", {31'd0, timeout}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) xfer(VEC[i]);

    // R1: either chip select inactive blocks acceptance
    no_accept(1'b1, 1'b1);
    no_accept(1'b0, 1'b0);
    xfer({1'b1, 5'h05, 8'h00, 8'd0, 8'h00, 8'h6B});

    // R9: interrupt forwarding independent of transfers
    @(negedge clk);
    usr_irq_n = 0;
    #1 chk("R9", "irq passthrough", {31'd0, irq_n}, 32'd0);
    @(negedge clk);
    chk("R9", "irq pending set", {31'd0, irq_pend}, 32'd1);
    xfer({1'b0, 5'h14, 8'h77, 8'd2, 8'h00, 8'h00});
    chk("R9", "irq held across transfer", {31'd0, irq_n}, 32'd0);
    chk("R9", "pending held", {31'd0, irq_pend}, 32'd1);
    usr_irq_n = 1;
    #1 chk("R9", "irq released", {31'd0, irq_n}, 32'd1);
    @(negedge clk);
    chk("R9", "pending cleared", {31'd0, irq_pend}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule